// File: doc/BRIEF.md
# Periodic Transaction Command Slot Manager

This block keeps the two-entry command queue of a periodic bus-transfer DMA engine. Transaction descriptors that the fetch logic delivers are placed in a free slot in arrival order. A slot is handed back only on one of three qualifying events:

- the final results of the transaction have reached the memory write buffers;
- a late-start failure, which also releases a younger entry loaded in the same microframe;
- a timeout of a high-bandwidth interrupt transaction. That transaction is dropped from the queue, and the scheduler presents it again the next time its endpoint comes up.

A free-running microframe timer is cleared at every microframe start. Once the timer exceeds a programmable cut-off, the block withdraws fetch permission, so no further structure or data reads begin in that interval. A host error freezes the queue contents and removes fetch permission. Only a controller reset releases the frozen state.

Every free event acts on the queue head. When several events arrive together, they consume entries from the oldest onward.

Top module: `ptx_slot_mgr`

## Requirements
- R1: A descriptor on `load_valid` is stored when fewer than two entries would remain after the same cycle's releases and no host error is present or latched. Otherwise it is dropped. `slot_avail` is high exactly when `occupancy` is below 2, and `head_tag` shows the oldest stored tag.
- R2: The microframe timer is cleared by `uframe_start` and counts up by one per cycle, saturating at its maximum. `fetch_en` is low whenever the timer value is greater than `cutoff`, and it stays low until the next `uframe_start`.
- R3: A `post_done` pulse removes the oldest entry, and the next entry becomes the head.
- R4: A `late_fail` pulse removes the oldest entry. It also removes the second entry when that entry was stored in the same microframe as the oldest one. An entry stored in a later microframe stays.
- R5: An `hb_timeout` pulse removes the oldest entry without putting it back, so the removed tag does not reappear in the queue.
- R6: Free events in the same cycle are summed and remove that many entries, oldest first, never more than are held. A load in that cycle lands behind the entries that survive.
- R7: A `host_err` pulse latches the locked state (`host_locked` high). From that cycle on, all free events and loads are ignored and `fetch_en` is low, even across microframe starts.
- R8: `ctrl_reset` empties the queue, clears the locked state and clears the timer, and this takes effect on the next cycle.
- R9: After `rst_n` is released, the queue is empty, `slot_avail` and `fetch_en` are high, and `host_locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset | input | 1 | Synchronous controller reset; clears queue, lock and timer |
| uframe_start | input | 1 | Microframe start pulse |
| cutoff | input | TIMER_W | Late-start cut-off compared with the timer |
| load_valid | input | 1 | A fetched descriptor is offered for a slot |
| load_tag | input | TAG_W | Identifier of the offered descriptor |
| post_done | input | 1 | Head transaction results posted to write buffers |
| late_fail | input | 1 | Late-start check failed for the head transaction |
| hb_timeout | input | 1 | High-bandwidth interrupt transaction timed out |
| host_err | input | 1 | Host error strobe |
| slot_avail | output | 1 | At least one slot is free |
| fetch_en | output | 1 | Structure and data reads may start |
| occupancy | output | 2 | Number of occupied slots |
| head_tag | output | TAG_W | Tag of the oldest entry |
| host_locked | output | 1 | Host error latched |

## Verification
If the slot state is corrupted, the fault shows up one cycle after the offending event: `occupancy`, `slot_avail` or `head_tag` disagree with the count the events imply. The tests cover a release in the wrong order, a same-frame partner that is not dropped, and a load that slips past a full queue. A timer that is wrong, or a lock that escapes, shows up on `fetch_en` at the exact cycle where the timer passes the cut-off. It also shows up in the first cycle after a host error. The tests drive events singly and in combination, with the expected queue computed in the bench.

// File: rtl/ptx_slot_mgr.sv
module ptx_slot_mgr #(
  parameter int TIMER_W = 10,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_reset,
  input  logic               uframe_start,
  input  logic [TIMER_W-1:0] cutoff,
  input  logic               load_valid,
  input  logic [TAG_W-1:0]   load_tag,
  input  logic               post_done,
  input  logic               late_fail,
  input  logic               hb_timeout,
  input  logic               host_err,
  output logic               slot_avail,
  output logic               fetch_en,
  output logic [1:0]         occupancy,
  output logic [TAG_W-1:0]   head_tag,
  output logic               host_locked
);

  logic [1:0]         vld;
  logic [TAG_W-1:0]   tag0, tag1;
  logic               frm0, frm1, cur_frm;
  logic [TIMER_W-1:0] tmr;
  logic               err_q;

  logic               blocked, take;
  logic [2:0]         held, sum, rel, remain;
  logic [TAG_W-1:0]   n_tag0, n_tag1;
  logic               n_frm0, n_frm1;
  logic [1:0]         n_vld;

  assign held        = {2'b0, vld[0]} + {2'b0, vld[1]};
  assign blocked     = err_q | host_err;
  assign occupancy   = held[1:0];
  assign slot_avail  = held < 3'd2;
  assign head_tag    = tag0;
  assign host_locked = err_q;
  assign fetch_en    = !err_q && !(tmr > cutoff);

  always_comb begin
    sum = {2'b0, post_done} + {2'b0, hb_timeout} + {2'b0, late_fail}
        + {2'b0, late_fail & vld[1] & (frm1 == frm0)};
    if (blocked)         rel = 3'd0;
    else if (sum > held) rel = held;
    else                 rel = sum;
    remain = held - rel;
    take   = load_valid && !blocked && (remain < 3'd2);

    n_tag0 = (rel == 3'd0) ? tag0 : tag1;
    n_frm0 = (rel == 3'd0) ? frm0 : frm1;
    n_tag1 = tag1;
    n_frm1 = frm1;
    if (take) begin
      if (remain == 3'd0) begin
        n_tag0 = load_tag;
        n_frm0 = cur_frm;
      end else begin
        n_tag1 = load_tag;
        n_frm1 = cur_frm;
      end
    end
    case (remain + {2'b0, take})
      3'd0:    n_vld = 2'b00;
      3'd1:    n_vld = 2'b01;
      default: n_vld = 2'b11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 2'b00; tag0 <= '0; tag1 <= '0; frm0 <= 1'b0; frm1 <= 1'b0;
      cur_frm <= 1'b0; tmr <= '0; err_q <= 1'b0;
    end else if (ctrl_reset) begin
      vld <= 2'b00; tag0 <= '0; tag1 <= '0; frm0 <= 1'b0; frm1 <= 1'b0;
      cur_frm <= 1'b0; tmr <= '0; err_q <= 1'b0;
    end else begin
      vld   <= n_vld;
      tag0  <= n_tag0;
      tag1  <= n_tag1;
      frm0  <= n_frm0;
      frm1  <= n_frm1;
      err_q <= err_q | host_err;
      if (uframe_start) begin
        tmr     <= '0;
        cur_frm <= ~cur_frm;
      end else if (tmr != '1) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  // R1
  queue_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld[1] |-> vld[0]);

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !ctrl_reset) |=> ($stable(vld) && $stable(tag0) && host_locked));

  // R7
  lock_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_locked |-> !fetch_en);

  // R8
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset |=> (occupancy == 2'd0 && !host_locked && fetch_en));

  // R2
  frame_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uframe_start && !ctrl_reset && !host_err && !err_q) |=> fetch_en);

  // R3
  post_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_done && !late_fail && !hb_timeout && !load_valid && !blocked
     && !ctrl_reset && vld == 2'b11) |=> (occupancy == 2'd1 && head_tag == $past(tag1)));

endmodule

// File: tb/test_ptx_slot_mgr.sv
module test_ptx_slot_mgr;
  localparam int TW = 10;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_reset = 0, uframe_start = 0, load_valid = 0;
  logic post_done = 0, late_fail = 0, hb_timeout = 0, host_err = 0;
  logic [TW-1:0] cutoff = TW'(1000);
  logic [GW-1:0] load_tag = '0;
  logic slot_avail, fetch_en, host_locked;
  logic [1:0] occupancy;
  logic [GW-1:0] head_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptx_slot_mgr #(.TIMER_W(TW), .TAG_W(GW)) i_ptx_slot_mgr (
    .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset), .uframe_start(uframe_start),
    .cutoff(cutoff), .load_valid(load_valid), .load_tag(load_tag),
    .post_done(post_done), .late_fail(late_fail), .hb_timeout(hb_timeout),
    .host_err(host_err), .slot_avail(slot_avail), .fetch_en(fetch_en),
    .occupancy(occupancy), .head_tag(head_tag), .host_locked(host_locked));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame();
    uframe_start = 1; tick(); uframe_start = 0;
  endtask

  task automatic load(input int t);
    load_valid = 1; load_tag = GW'(t); tick(); load_valid = 0;
  endtask

  task automatic t_reset();
    chk("R9 occupancy", occupancy, 0);
    chk("R9 slot_avail", slot_avail, 1);
    chk("R9 fetch_en", fetch_en, 1);
    chk("R9 host_locked", host_locked, 0);
  endtask

  task automatic t_fill();
    frame();
    load(5);
    chk("R1 occ after first load", occupancy, 1);
    chk("R1 head first", head_tag, 5);
    load(6);
    chk("R1 occ full", occupancy, 2);
    chk("R1 slot_avail full", slot_avail, 0);
    load(7);
    chk("R1 load when full dropped", occupancy, 2);
    chk("R1 head unchanged", head_tag, 5);
  endtask

  task automatic t_post();
    post_done = 1; tick(); post_done = 0;
    chk("R3 occ after post", occupancy, 1);
    chk("R3 next head", head_tag, 6);
    post_done = 1; tick(); post_done = 0;
    chk("R3 empty", occupancy, 0);
    chk("R3 slot_avail", slot_avail, 1);
  endtask

  task automatic t_timeout();
    load(2); load(3);
    hb_timeout = 1; tick(); hb_timeout = 0;
    chk("R5 occ after timeout", occupancy, 1);
    chk("R5 timed-out tag gone", head_tag, 3);
    post_done = 1; tick(); post_done = 0;
    chk("R5 drained", occupancy, 0);
  endtask

  task automatic t_late_same();
    frame();
    load(1); load(2);
    late_fail = 1; tick(); late_fail = 0;
    chk("R4 same-frame pair released", occupancy, 0);
  endtask

  task automatic t_late_diff();
    frame(); load(3);
    frame(); load(4);
    late_fail = 1; tick(); late_fail = 0;
    chk("R4 later-frame entry kept", occupancy, 1);
    chk("R4 head is later entry", head_tag, 4);
    post_done = 1; tick(); post_done = 0;
  endtask

  task automatic t_multi();
    frame(); load(8); load(9);
    post_done = 1; hb_timeout = 1; tick(); post_done = 0; hb_timeout = 0;
    chk("R6 two events free two", occupancy, 0);
    load(8); load(9);
    post_done = 1; load_valid = 1; load_tag = GW'(10); tick();
    post_done = 0; load_valid = 0;
    chk("R6 release then load occ", occupancy, 2);
    chk("R6 oldest released first", head_tag, 9);
    post_done = 1; hb_timeout = 1; late_fail = 1; tick();
    post_done = 0; hb_timeout = 0; late_fail = 0;
    chk("R6 excess events clamp", occupancy, 0);
  endtask

  task automatic t_cutoff();
    cutoff = TW'(3);
    frame();
    chk("R2 open at timer 0", fetch_en, 1);
    tick(); tick(); tick();
    chk("R2 open at timer equal cutoff", fetch_en, 1);
    tick();
    chk("R2 closed past cutoff", fetch_en, 0);
    tick();
    chk("R2 stays closed", fetch_en, 0);
    frame();
    chk("R2 reopens on frame start", fetch_en, 1);
    cutoff = TW'(1000);
  endtask

  task automatic t_host_err();
    frame(); load(11);
    host_err = 1; post_done = 1; tick(); host_err = 0; post_done = 0;
    chk("R7 release in error cycle ignored", occupancy, 1);
    chk("R7 locked", host_locked, 1);
    chk("R7 fetch low", fetch_en, 0);
    post_done = 1; hb_timeout = 1; tick(); post_done = 0; hb_timeout = 0;
    chk("R7 releases ignored", occupancy, 1);
    load(12);
    chk("R7 load ignored", occupancy, 1);
    chk("R7 head kept", head_tag, 11);
    frame();
    chk("R7 fetch stays low over frame", fetch_en, 0);
    ctrl_reset = 1; tick(); ctrl_reset = 0;
    chk("R8 queue emptied", occupancy, 0);
    chk("R8 lock cleared", host_locked, 0);
    chk("R8 fetch restored", fetch_en, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_post();
    t_timeout();
    t_late_same();
    t_late_diff();
    t_multi();
    t_cutoff();
    t_host_err();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule